// File: doc/BRIEF.md
# Memory Request Classifier and Issuer

This block sits between a processor's memory port and a first-level cache controller. Each cycle it looks at the attribute flags of the access being offered. These flags are read, write, flush, reserved-pair (load-linked / store-conditional), locked read-modify-write, instruction fetch and store-check. From them it derives two class codes. The primary class is what a request tracker records. The secondary class is what the cache controller is asked to do. An access that matches none of the recognised attribute combinations is flagged as unsupported.

When the tracker accepts the access, the block issues it to the cache controller after a hit latency. The secondary class selects that latency: instruction fetches use the instruction-cache latency and all other classes use the data-cache latency. Only one request occupies the delay stage at a time. While it is occupied, the ready output is low, and any new offer is neither accepted nor issued.

Top module: `mem_req_issuer`

## Requirements
- R1: Class codes are 4 bits: none=0, load=1, ifetch=2, store=3, rmw_read=4, flush=5, load_linked=6, store_cond=7, locked_rd=8, locked_wr=9, atomic=10. A reserved-pair access (`req_pair` high) has the highest priority. It gives primary store_cond when `req_wr` is high and load_linked otherwise, and its secondary class is atomic.
- R2: A locked access (`req_lock` high, `req_pair` low) gives primary locked_wr when `req_wr` is high and locked_rd otherwise. Its secondary class is store.
- R3: For an ordinary access, the write flag is tested before the read flag. Any access with `req_wr` high, including one with both `req_rd` and `req_wr` high (a swap), gives store for both codes.
- R4: An ordinary read (`req_rd` high, `req_wr` low) with `req_ifetch` high gives ifetch for both codes, whatever `req_stchk` is.
- R5: An ordinary data read with `req_stchk` high gives primary rmw_read and secondary store. Without `req_stchk`, it gives load for both codes.
- R6: An ordinary access that is neither a read nor a write but has `req_flush` high gives flush for both codes. A valid access with none of the flags `req_pair`, `req_lock`, `req_wr`, `req_rd`, `req_flush` drives `unsupported` high and both codes to none. With `req_valid` low, both codes are none and `unsupported` is low.
- R7: An accepted request produces a one-cycle `iss_valid` pulse with its address on `iss_addr` and its secondary class on `iss_class`. If the acceptance edge is edge k, the pulse is visible after edge k+L. L is `ICACHE_LAT` when the secondary class is ifetch and `DCACHE_LAT` otherwise.
- R8: A request is accepted only on an edge where `req_valid`, `accept` and `ready` are high and `unsupported` is low. An offer refused by the tracker, or one that is unsupported, is never issued.
- R9: `ready` falls after the acceptance edge and stays low until the edge on which the issue pulse appears. Offers made while `ready` is low are ignored and produce no pulse.
- R10: After reset, `ready` is high and `iss_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | An access is offered this cycle |
| req_rd | input | 1 | Access reads memory |
| req_wr | input | 1 | Access writes memory |
| req_flush | input | 1 | Access is a line flush |
| req_pair | input | 1 | Access is half of a reserved load/conditional-store pair |
| req_lock | input | 1 | Access is part of a locked read-modify-write |
| req_ifetch | input | 1 | Read is an instruction fetch |
| req_stchk | input | 1 | Data read must gain write permission |
| req_addr | input | ADDR_W | Access address |
| accept | input | 1 | Tracker accepts the offered access |
| ready | output | 1 | Delay stage is free |
| cls_pri | output | 4 | Primary class code (combinational) |
| cls_sec | output | 4 | Secondary class code (combinational) |
| unsupported | output | 1 | Offered access has no recognised attributes |
| iss_valid | output | 1 | One-cycle issue strobe to the cache controller |
| iss_addr | output | ADDR_W | Address of the issued request |
| iss_class | output | 4 | Secondary class of the issued request |

## Verification
The class codes and the unsupported flag are combinational, so the bench reads them in the same cycle, shortly after driving the inputs on the falling edge. When the bench offers a request at cycle count N, it predicts acceptance at edge N+1 and a strobe at count N+1+L, with L taken from the secondary class. It queues that due count and also keeps its own model of when the stage becomes free, which it compares against `ready`. A monitor on the falling edge pops the queue on every strobe and checks the address, the class and the exact cycle. It also reports a strobe that nobody expected and a strobe that never came.

// File: rtl/mri_pkg.sv
package mri_pkg;

    typedef enum logic [3:0] {
        CLS_NONE     = 4'd0,
        CLS_LOAD     = 4'd1,
        CLS_IFETCH   = 4'd2,
        CLS_STORE    = 4'd3,
        CLS_RMW_RD   = 4'd4,
        CLS_FLUSH    = 4'd5,
        CLS_LL       = 4'd6,
        CLS_SC       = 4'd7,
        CLS_LOCK_RD  = 4'd8,
        CLS_LOCK_WR  = 4'd9,
        CLS_ATOMIC   = 4'd10
    } req_class_e;

endpackage

// File: rtl/mri_classifier.sv
module mri_classifier
    import mri_pkg::*;
(
    input  logic       valid,
    input  logic       rd,
    input  logic       wr,
    input  logic       flush,
    input  logic       pair,
    input  logic       lock,
    input  logic       ifetch,
    input  logic       stchk,
    output req_class_e pri,
    output req_class_e sec,
    output logic       unsup
);

    // Priority: reserved pair, then locked RMW, then write, read, flush.
    always_comb begin
        pri   = CLS_NONE;
        sec   = CLS_NONE;
        unsup = 1'b0;
        if (valid) begin
            if (pair) begin
                pri = wr ? CLS_SC : CLS_LL;
                sec = CLS_ATOMIC;
            end else if (lock) begin
                pri = wr ? CLS_LOCK_WR : CLS_LOCK_RD;
                sec = CLS_STORE;
            end else if (wr) begin
                pri = CLS_STORE;
                sec = CLS_STORE;
            end else if (rd) begin
                if (ifetch) begin
                    pri = CLS_IFETCH;
                    sec = CLS_IFETCH;
                end else if (stchk) begin
                    pri = CLS_RMW_RD;
                    sec = CLS_STORE;
                end else begin
                    pri = CLS_LOAD;
                    sec = CLS_LOAD;
                end
            end else if (flush) begin
                pri = CLS_FLUSH;
                sec = CLS_FLUSH;
            end else begin
                unsup = 1'b1;
            end
        end
    end

endmodule

// File: rtl/mri_lat_sel.sv
module mri_lat_sel
    import mri_pkg::*;
#(
    parameter int ILAT  = 2,
    parameter int DLAT  = 3,
    parameter int CNT_W = 2
) (
    input  req_class_e       sec,
    output logic [CNT_W-1:0] lat
);

    localparam logic [CNT_W-1:0] ILAT_V = CNT_W'(ILAT);
    localparam logic [CNT_W-1:0] DLAT_V = CNT_W'(DLAT);

    always_comb begin
        lat = (sec == CLS_IFETCH) ? ILAT_V : DLAT_V;
    end

endmodule

// File: rtl/mri_delay.sv
module mri_delay
    import mri_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [CNT_W-1:0]  lat,
    input  logic [ADDR_W-1:0] addr,
    input  req_class_e        cls,
    output logic              ready,
    output logic              iss_valid,
    output logic [ADDR_W-1:0] iss_addr,
    output req_class_e        iss_cls
);

    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic              iss;
        logic [ADDR_W-1:0] addr;
        req_class_e        cls;
    } dly_st_t;

    dly_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.iss = 1'b0;
        if (st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - 1'b1;
            if (st_q.cnt == CNT_W'(1)) begin
                st_d.iss = 1'b1;
            end
        end else if (start) begin
            st_d.cnt  = lat;
            st_d.addr = addr;
            st_d.cls  = cls;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ready     = (st_q.cnt == '0);
    assign iss_valid = st_q.iss;
    assign iss_addr  = st_q.addr;
    assign iss_cls   = st_q.cls;

endmodule

// File: rtl/mem_req_issuer.sv
module mem_req_issuer
    import mri_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int ICACHE_LAT = 2,
    parameter int DCACHE_LAT = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_rd,
    input  logic              req_wr,
    input  logic              req_flush,
    input  logic              req_pair,
    input  logic              req_lock,
    input  logic              req_ifetch,
    input  logic              req_stchk,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              accept,
    output logic              ready,
    output logic [3:0]        cls_pri,
    output logic [3:0]        cls_sec,
    output logic              unsupported,
    output logic              iss_valid,
    output logic [ADDR_W-1:0] iss_addr,
    output logic [3:0]        iss_class
);

    // A latency of zero is not meaningful; clamp to one cycle.
    localparam int ILAT_EFF = (ICACHE_LAT < 1) ? 1 : ICACHE_LAT;
    localparam int DLAT_EFF = (DCACHE_LAT < 1) ? 1 : DCACHE_LAT;
    localparam int LAT_MAX  = (ILAT_EFF > DLAT_EFF) ? ILAT_EFF : DLAT_EFF;
    localparam int CNT_W    = $clog2(LAT_MAX + 1);

    req_class_e       pri_c, sec_c, iss_cls_c;
    logic             unsup_c;
    logic [CNT_W-1:0] lat_c;
    logic             start_c;

    mri_classifier u_cls (
        .valid  (req_valid),
        .rd     (req_rd),
        .wr     (req_wr),
        .flush  (req_flush),
        .pair   (req_pair),
        .lock   (req_lock),
        .ifetch (req_ifetch),
        .stchk  (req_stchk),
        .pri    (pri_c),
        .sec    (sec_c),
        .unsup  (unsup_c)
    );

    mri_lat_sel #(
        .ILAT  (ILAT_EFF),
        .DLAT  (DLAT_EFF),
        .CNT_W (CNT_W)
    ) u_lat (
        .sec (sec_c),
        .lat (lat_c)
    );

    assign start_c = req_valid & accept & ready & ~unsup_c;

    mri_delay #(
        .ADDR_W (ADDR_W),
        .CNT_W  (CNT_W)
    ) u_dly (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start_c),
        .lat       (lat_c),
        .addr      (req_addr),
        .cls       (sec_c),
        .ready     (ready),
        .iss_valid (iss_valid),
        .iss_addr  (iss_addr),
        .iss_cls   (iss_cls_c)
    );

    assign cls_pri     = pri_c;
    assign cls_sec     = sec_c;
    assign unsupported = unsup_c;
    assign iss_class   = iss_cls_c;

endmodule

// File: rtl/mri_checker.sv
module mri_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       req_valid,
    input logic       req_wr,
    input logic       req_pair,
    input logic       req_lock,
    input logic       accept,
    input logic       ready,
    input logic [3:0] cls_pri,
    input logic [3:0] cls_sec,
    input logic       unsupported,
    input logic       iss_valid
);

    // R6: an unsupported access carries no class
    p_unsup_none_r6: assert property (@(posedge clk) disable iff (!rst_n)
        unsupported |-> (cls_pri == 4'd0 && cls_sec == 4'd0));

    // R3: ordinary write (including swap) is a store
    p_write_store_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_pair && !req_lock && req_wr) |-> (cls_pri == 4'd3 && cls_sec == 4'd3));

    // R1: reserved-pair secondary class is atomic
    p_pair_atomic_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_pair) |-> (cls_sec == 4'd10));

    // R9: an accepted request makes the stage busy
    p_busy_after_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && accept && ready && !unsupported) |=> !ready);

    // R8: a strobe only follows a busy stage
    p_issue_from_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        iss_valid |-> !$past(ready));

    // R7: the strobe lasts a single cycle
    p_single_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        iss_valid |=> !iss_valid);

endmodule

bind mem_req_issuer mri_checker u_mri_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_wr      (req_wr),
    .req_pair    (req_pair),
    .req_lock    (req_lock),
    .accept      (accept),
    .ready       (ready),
    .cls_pri     (cls_pri),
    .cls_sec     (cls_sec),
    .unsupported (unsupported),
    .iss_valid   (iss_valid)
);

// File: tb/tb_mem_req_issuer.sv
module tb_mem_req_issuer;

    localparam int AW   = 32;
    localparam int ILAT = 2;
    localparam int DLAT = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic v = 0, rd = 0, wr = 0, fl = 0, pr = 0, lk = 0, ifc = 0, sc = 0, acc = 0;
    logic [AW-1:0] addr = '0;
    logic ready, unsupported, iss_valid;
    logic [3:0] cls_pri, cls_sec, iss_class;
    logic [AW-1:0] iss_addr;

    int cyc = 0;
    int checks = 0;
    int fails = 0;
    int free_at = 0;

    typedef struct {
        logic [AW-1:0] a;
        int            c;
        int            due;
    } exp_t;
    exp_t sb[$];

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    mem_req_issuer #(.ADDR_W(AW), .ICACHE_LAT(ILAT), .DCACHE_LAT(DLAT)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(v), .req_rd(rd), .req_wr(wr),
        .req_flush(fl), .req_pair(pr), .req_lock(lk), .req_ifetch(ifc),
        .req_stchk(sc), .req_addr(addr), .accept(acc), .ready(ready),
        .cls_pri(cls_pri), .cls_sec(cls_sec), .unsupported(unsupported),
        .iss_valid(iss_valid), .iss_addr(iss_addr), .iss_class(iss_class)
    );

    function automatic void chk(input bit ok, input string rq, input string what,
                                input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
        end
    endfunction

    // Monitor: pops the scoreboard on each strobe (R7, R8, R9)
    always @(negedge clk) begin
        if (rst_n) begin
            if (iss_valid) begin
                if (sb.size() == 0) begin
                    chk(1'b0, "R8", "unexpected strobe class", int'(iss_class), -1);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    chk(cyc == e.due, "R7", "strobe cycle", cyc, e.due);
                    chk(iss_addr == e.a, "R7", "strobe addr", int'(iss_addr), int'(e.a));
                    chk(int'(iss_class) == e.c, "R7", "strobe class", int'(iss_class), e.c);
                end
            end else if (sb.size() != 0 && sb[0].due <= cyc) begin
                exp_t e;
                e = sb.pop_front();
                chk(1'b0, "R7", "missing strobe due", cyc, e.due);
            end
        end
    end

    task automatic req(input bit r, w, f, p, l, i, s, input logic [AW-1:0] a,
                       input bit ac, input int ep, input int es, input bit eu,
                       input string rq);
        bit exp_rdy;
        @(negedge clk);
        v = 1; rd = r; wr = w; fl = f; pr = p; lk = l; ifc = i; sc = s;
        addr = a; acc = ac;
        #1;
        chk(int'(cls_pri) == ep && int'(cls_sec) == es && unsupported == eu, rq,
            "class pri/sec/unsup", int'({cls_pri, cls_sec, unsupported}),
            int'({ep[3:0], es[3:0], eu}));
        exp_rdy = (cyc >= free_at);
        chk(ready == exp_rdy, "R9", "ready at offer", int'(ready), int'(exp_rdy));
        if (exp_rdy && ac && !eu) begin
            int lat;
            exp_t e;
            lat = (es == 2) ? ILAT : DLAT;
            e.a = a; e.c = es; e.due = cyc + 1 + lat;
            sb.push_back(e);
            free_at = cyc + 1 + lat;
        end
    endtask

    task automatic idle();
        @(negedge clk);
        v = 0; acc = 0; rd = 0; wr = 0; fl = 0; pr = 0; lk = 0; ifc = 0; sc = 0;
        #1;
        chk(cls_pri == 4'd0 && cls_sec == 4'd0 && !unsupported, "R6", "idle codes",
            int'({cls_pri, cls_sec, unsupported}), 0);
        for (int k = 0; k < 12; k++) begin
            if (sb.size() == 0 && cyc >= free_at) break;
            @(negedge clk);
        end
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        chk(1'b0, "R7", "watchdog expired", cyc, 0);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        chk(ready == 1'b1, "R10", "ready in reset", int'(ready), 1);
        rst_n = 1;
        @(negedge clk); #1;
        chk(ready == 1'b1 && iss_valid == 1'b0, "R10", "ready/iss after reset",
            int'({ready, iss_valid}), 2);
        free_at = cyc;

        //        rd wr fl pr lk if sc  addr          acc pri sec uns
        req(1, 0, 0, 1, 0, 0, 0, 32'h0000_1000, 1, 6, 10, 0, "R1"); idle();
        req(0, 1, 0, 1, 0, 0, 0, 32'h0000_1040, 1, 7, 10, 0, "R1"); idle();
        req(1, 0, 0, 1, 1, 0, 0, 32'h0000_1080, 1, 6, 10, 0, "R1"); idle();
        req(1, 0, 0, 0, 1, 0, 0, 32'h0000_2000, 1, 8, 3, 0, "R2"); idle();
        req(0, 1, 0, 0, 1, 0, 0, 32'h0000_2040, 1, 9, 3, 0, "R2"); idle();
        req(0, 1, 0, 0, 0, 0, 0, 32'h0000_3000, 1, 3, 3, 0, "R3"); idle();
        req(1, 1, 0, 0, 0, 0, 0, 32'h0000_3040, 1, 3, 3, 0, "R3"); idle();
        req(1, 0, 0, 0, 0, 1, 0, 32'h0000_4000, 1, 2, 2, 0, "R4"); idle();
        req(1, 0, 0, 0, 0, 1, 1, 32'h0000_4040, 1, 2, 2, 0, "R4"); idle();
        req(1, 0, 0, 0, 0, 0, 1, 32'h0000_5000, 1, 4, 3, 0, "R5"); idle();
        req(1, 0, 0, 0, 0, 0, 0, 32'h0000_5040, 1, 1, 1, 0, "R5"); idle();
        req(0, 0, 1, 0, 0, 0, 0, 32'h0000_6000, 1, 5, 5, 0, "R6"); idle();
        req(0, 0, 0, 0, 0, 0, 0, 32'h0000_6040, 1, 0, 0, 1, "R6"); idle();
        // R8: tracker refusal is never issued
        req(1, 0, 0, 0, 0, 0, 0, 32'h0000_7000, 0, 1, 1, 0, "R8"); idle();
        // R9: offers while busy are ignored
        req(1, 0, 0, 0, 0, 0, 0, 32'h0000_8000, 1, 1, 1, 0, "R9");
        req(1, 0, 0, 0, 0, 1, 0, 32'h0000_8040, 1, 2, 2, 0, "R9");
        req(0, 1, 0, 0, 0, 0, 0, 32'h0000_8080, 1, 3, 3, 0, "R9");
        idle();
        // R7: back-to-back instruction then data, different latencies
        req(1, 0, 0, 0, 0, 1, 0, 32'h0000_9000, 1, 2, 2, 0, "R7");
        req(1, 0, 0, 0, 0, 1, 0, 32'h0000_9004, 1, 2, 2, 0, "R7");
        req(1, 0, 0, 0, 0, 1, 0, 32'h0000_9008, 1, 2, 2, 0, "R7");
        req(0, 1, 0, 0, 0, 0, 0, 32'h0000_9100, 1, 3, 3, 0, "R7");
        idle();
        idle();

        chk(sb.size() == 0, "R7", "scoreboard drained", sb.size(), 0);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule